// File: doc/BRIEF.md
# Variable-Width Cycle-Counting Interrupt Timer

This block counts processor cycles down from a value that software loads, and raises an interrupt request when the count runs out. The reload value is assembled from four nibbles, each written separately. A single control write enables counting and picks how many low bits of the 16-bit counter take part in the count: 4, 8, 12 or all 16. Only the selected low bits are decremented, and they wrap within their own width. The bits above them keep their value. The request is a level signal. It stays high until software acknowledges it with a load write or a control write.

The block sits on a processor's register write path. Each write presents an address, a 4-bit data value and a one-cycle strobe. The block has no ready signal: a write is taken on every clock in which the strobe is high, so nothing at this edge can apply back-pressure. A separate one-cycle strobe marks each processor cycle. The decode looks only at address bits 15:12 and 1:0. Every other address bit is a don't-care.

Top module: `irq_timer`

## Requirements
- R1: A write whose address matches 0xE000 under mask 0xF003 stores wr_data as reload nibble k, where k is address bits 1:0. Nibble 0 is reload bits 3:0 and nibble 3 is reload bits 15:12.
- R2: A write to 0xF000 (under mask 0xF003) loads the counter with the 16-bit reload value and clears a pending request. This load overrides any decrement in the same clock.
- R3: A write to 0xF001 (under mask 0xF003) clears a pending request and sets the enable from wr_data bit 0.
- R4: The same 0xF001 write selects the count width by priority. If bit 3 is set the width is 4 bits (mask 0x000F). Otherwise, if bit 2 is set it is 8 bits (0x00FF). Otherwise, if bit 1 is set it is 12 bits (0x0FFF). Otherwise it is 16 bits (0xFFFF).
- R5: On a counting step, only the counter bits inside the mask are decremented. Bits outside the mask keep their value.
- R6: A counting step whose decremented masked value is zero makes the request pending, with irq high after that clock edge. A reload of 1 therefore fires on the first step, and an 8-bit reload of 0x0011 fires on the 17th step.
- R7: If the masked value is already zero before a step, the step wraps it to the mask value and does not raise the request.
- R8: While the enable is clear, the counter holds its value and no request is raised.
- R9: irq is active-high and stays high until a write to 0xF000 or 0xF001 clears it.
- R10: When an acknowledging write and a firing step fall in the same clock, the acknowledge wins and irq is low afterwards.
- R11: Reset clears the reload nibbles, the counter, the width select (to 16 bits), the enable and the pending request.
- R12: A step happens only in a clock where cpu_tick is high. Without cpu_tick the counter does not move.
- R13: Writes whose masked address is none of 0xE000 to 0xE003, 0xF000 or 0xF001 (for example 0xF002, 0xF003, 0x8000, 0xD001) change nothing, and a pending irq stays high through them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one write per clock |
| wr_addr | input | 16 | Write address |
| wr_data | input | 4 | Write data nibble |
| cpu_tick | input | 1 | High for one clock per processor cycle |
| irq | output | 1 | Level interrupt request, active high |

## Verification
The assertions assume nothing about how writes and cycle strobes are spaced. They must hold even when an acknowledge, a load or a width change lands in the same clock as a counting step. The stimulus therefore includes directed clocks in which those events coincide, followed by a long random run in which writes to every decoded and ignored address are mixed freely with cycle strobes. The only input assumption is that all inputs carry known values from the end of reset onward, and the bench drives every input from time zero.

// File: rtl/irq_timer_pkg.sv
package irq_timer_pkg;
  localparam int ADDR_W = 16;
  localparam logic [ADDR_W-1:0] DEC_MASK  = 16'hF003;
  localparam logic [ADDR_W-1:0] A_RELOAD  = 16'hE000;
  localparam logic [ADDR_W-1:0] A_LOAD    = 16'hF000;
  localparam logic [ADDR_W-1:0] A_CTRL    = 16'hF001;
endpackage

// File: rtl/irq_timer_regs.sv
module irq_timer_regs
  import irq_timer_pkg::*;
#(
  parameter int NIB_W   = 4,
  parameter int NIB_CNT = 4,
  parameter int SEL_W   = $clog2(NIB_CNT),
  parameter int CNT_W   = NIB_W * NIB_CNT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [NIB_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  reload_val,
  output logic              load_hit,
  output logic              ack_hit,
  output logic              enable_q,
  output logic [SEL_W-1:0]  width_q
);
  logic [ADDR_W-1:0] dec_addr;
  logic              reload_hit;
  logic              ctrl_hit;
  logic [SEL_W-1:0]  nib_idx;
  logic [SEL_W-1:0]  width_d;

  assign dec_addr   = wr_addr & DEC_MASK;
  assign reload_hit = wr_en && ((dec_addr & ~ADDR_W'(NIB_CNT - 1)) == A_RELOAD);
  assign load_hit   = wr_en && (dec_addr == A_LOAD);
  assign ctrl_hit   = wr_en && (dec_addr == A_CTRL);
  assign ack_hit    = load_hit || ctrl_hit;
  assign nib_idx    = wr_addr[SEL_W-1:0];

  // Highest set bit among data[NIB_CNT-1:1] picks the narrowest width.
  always_comb begin
    width_d = '0;
    for (int i = 1; i < NIB_CNT; i++) begin
      if (wr_data[i]) width_d = SEL_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_val <= '0;
    end else if (reload_hit) begin
      for (int i = 0; i < NIB_CNT; i++) begin
        if (nib_idx == SEL_W'(i)) reload_val[i*NIB_W +: NIB_W] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable_q <= 1'b0;
      width_q  <= '0;
    end else if (ctrl_hit) begin
      enable_q <= wr_data[0];
      width_q  <= width_d;
    end
  end
endmodule

// File: rtl/irq_timer_count.sv
module irq_timer_count #(
  parameter int NIB_W   = 4,
  parameter int NIB_CNT = 4,
  parameter int SEL_W   = $clog2(NIB_CNT),
  parameter int CNT_W   = NIB_W * NIB_CNT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             enable,
  input  logic [SEL_W-1:0] width_sel,
  input  logic             load,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             ack,
  output logic [CNT_W-1:0] count_q,
  output logic             irq
);
  localparam logic [CNT_W-1:0] ONES = {CNT_W{1'b1}};

  logic [CNT_W-1:0] mask;
  logic [CNT_W-1:0] low_dec;
  logic             step;
  logic             fire;

  always_comb begin
    mask    = ONES >> (32'(width_sel) * NIB_W);
    low_dec = ((count_q & mask) - 1'b1) & mask;
    step    = tick && enable;
    fire    = step && (low_dec == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     count_q <= '0;
    else if (load)  count_q <= reload_val;
    else if (step)  count_q <= (count_q & ~mask) | low_dec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     irq <= 1'b0;
    else if (ack)   irq <= 1'b0;
    else if (fire)  irq <= 1'b1;
  end
endmodule

// File: rtl/irq_timer.sv
module irq_timer
  import irq_timer_pkg::*;
#(
  parameter int NIB_W   = 4,
  parameter int NIB_CNT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [NIB_W-1:0]  wr_data,
  input  logic              cpu_tick,
  output logic              irq
);
  localparam int SEL_W = $clog2(NIB_CNT);
  localparam int CNT_W = NIB_W * NIB_CNT;

  logic [CNT_W-1:0] reload_val;
  logic [CNT_W-1:0] count_q;
  logic             load_hit;
  logic             ack_hit;
  logic             enable_q;
  logic [SEL_W-1:0] width_q;

  irq_timer_regs #(.NIB_W(NIB_W), .NIB_CNT(NIB_CNT), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .reload_val(reload_val), .load_hit(load_hit), .ack_hit(ack_hit),
    .enable_q(enable_q), .width_q(width_q)
  );

  irq_timer_count #(.NIB_W(NIB_W), .NIB_CNT(NIB_CNT), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .tick(cpu_tick), .enable(enable_q), .width_sel(width_q),
    .load(load_hit), .reload_val(reload_val), .ack(ack_hit),
    .count_q(count_q), .irq(irq)
  );
endmodule

// File: rtl/irq_timer_chk.sv
module irq_timer_chk #(
  parameter int NIB_W = 4,
  parameter int SEL_W = 2,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_tick,
  input logic             irq,
  input logic             load_hit,
  input logic             ack_hit,
  input logic             enable_q,
  input logic [SEL_W-1:0] width_q,
  input logic [CNT_W-1:0] reload_val,
  input logic [CNT_W-1:0] count_q
);
  localparam logic [CNT_W-1:0] ONES = {CNT_W{1'b1}};

  // R2: the counter takes the reload value one clock after a load write.
  assert_load_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_hit |=> (count_q == $past(reload_val)));

  // R5: a step leaves the bits above the selected width unchanged.
  assert_upper_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_hit && cpu_tick && enable_q) |=>
      (((count_q ^ $past(count_q)) & ~(ONES >> (32'($past(width_q)) * NIB_W))) == '0));

  // R8 and R12: with no enabled tick and no load, the counter holds.
  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_hit && !(cpu_tick && enable_q)) |=> $stable(count_q));

  // R6: the request rises only after an enabled tick.
  assert_rise_on_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(cpu_tick && enable_q));

  // R9: a pending request stays until acknowledged.
  assert_level_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack_hit) |=> irq);

  // R10: an acknowledge always leaves the request low.
  assert_ack_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ack_hit |=> !irq);
endmodule

bind irq_timer irq_timer_chk #(.NIB_W(NIB_W), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_tick(cpu_tick), .irq(irq),
  .load_hit(load_hit), .ack_hit(ack_hit), .enable_q(enable_q),
  .width_q(width_q), .reload_val(reload_val), .count_q(count_q)
);

// File: tb/irq_timer_test.sv
module irq_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [3:0]  wr_data = '0;
  logic        cpu_tick = 1'b0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural reference state
  int m_nib[4];
  int m_cnt, m_wid, m_en, m_pend;

  always #4 clk = ~clk;

  irq_timer uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
                 .wr_data(wr_data), .cpu_tick(cpu_tick), .irq(irq));

  task automatic model_reset();
    for (int i = 0; i < 4; i++) m_nib[i] = 0;
    m_cnt = 0; m_wid = 16; m_en = 0; m_pend = 0;
  endtask

  task automatic model_step(input bit we, input int a, input int d, input bit t);
    int msk, low, fire, sel;
    fire = 0;
    if (t && m_en != 0) begin
      msk = (1 << m_wid) - 1;
      low = ((m_cnt & msk) + msk) & msk;   // minus one, wrapped in the width
      m_cnt = (m_cnt & ~msk & 32'hFFFF) | low;
      fire = (low == 0);
    end
    if (fire) m_pend = 1;
    if (we) begin
      sel = a & 32'hF003;
      if (sel >= 32'hE000 && sel <= 32'hE003) m_nib[sel & 3] = d;
      else if (sel == 32'hF000) begin
        m_cnt = m_nib[0] + 16 * m_nib[1] + 256 * m_nib[2] + 4096 * m_nib[3];
        m_pend = 0;
      end else if (sel == 32'hF001) begin
        m_pend = 0;
        m_en = d & 1;
        if (d & 8) m_wid = 4;
        else if (d & 4) m_wid = 8;
        else if (d & 2) m_wid = 12;
        else m_wid = 16;
      end
    end
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: irq actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(input bit we, input int a, input int d, input bit t, input string tag);
    wr_en = we; wr_addr = a[15:0]; wr_data = d[3:0]; cpu_tick = t;
    @(posedge clk);
    model_step(we, a, d, t);
    @(negedge clk);
    wr_en = 1'b0; cpu_tick = 1'b0;
    check(tag, int'(irq), m_pend);
  endtask

  task automatic wr(input int a, input int d, input string tag);
    cyc(1'b1, a, d, 1'b0, tag);
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 0, 0, 1'b1, tag);
  endtask

  task automatic set_reload(input int v, input string tag);
    for (int i = 0; i < 4; i++) wr(32'hE000 + i, (v >> (4 * i)) & 15, tag);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    check("R11 reset", int'(irq), 0);
    rst_n = 1'b1;

    // R8: ticks with enable clear after reset raise nothing
    ticks(5, "R8 disabled after reset");

    // R1 R6: reload of 1 fires on the first step
    set_reload(1, "R1");
    wr(32'hF001, 1, "R3 enable");
    wr(32'hF000, 0, "R2 load");
    ticks(1, "R6 reload one");
    // R7 R9: masked zero wraps without firing, request holds
    ticks(3, "R7 R9 hold");
    repeat (3) cyc(1'b0, 0, 0, 1'b0, "R9 hold idle");
    // R13: ignored addresses keep the request
    wr(32'hF002, 15, "R13 ignored");
    wr(32'hF003, 15, "R13 ignored");
    wr(32'h8000, 1, "R13 ignored");
    wr(32'hD001, 1, "R13 ignored");
    // R3: control write acknowledges and disables
    wr(32'hF001, 0, "R3 ack disable");
    ticks(20, "R8 disabled");

    // R4 R6: 8-bit width, reload 0x0011 fires on step 17
    set_reload(32'h0011, "R1 nibbles");
    wr(32'hF001, 5, "R4 8-bit");
    wr(32'hF000, 0, "R2 load");
    ticks(16, "R6 before 17th");
    ticks(1, "R6 17th step");
    wr(32'hF000, 0, "R2 ack by load");

    // R5: 4-bit width on 0x1203 fires after 3, upper bits kept
    set_reload(32'h1203, "R1 positions");
    wr(32'hF001, 9, "R4 4-bit");
    wr(32'hF000, 0, "R2 load");
    ticks(3, "R5 low nibble");
    wr(32'hF001, 9, "R3 ack");
    ticks(16, "R7 R5 wrap in nibble");
    wr(32'hF001, 1, "R4 16-bit");
    ticks(32'h1200 - 16, "R5 upper kept");
    ticks(20, "R5 upper fire");
    wr(32'hF001, 1, "R3 ack");

    // R4 priority: 0xF -> 4-bit, 0x7 -> 8-bit, 0x3 -> 12-bit
    set_reload(32'h2345, "R1");
    wr(32'hF001, 15, "R4 bit3 wins");
    wr(32'hF000, 0, "R2");
    ticks(6, "R4 4-bit priority");
    wr(32'hF001, 7, "R4 bit2 wins");
    wr(32'hF000, 0, "R2");
    ticks(70, "R4 8-bit priority");
    wr(32'hF001, 3, "R4 bit1 wins");
    wr(32'hF000, 0, "R2");
    ticks(32'h345 + 2, "R4 12-bit priority");

    // R10: acknowledge in the same clock as a firing step
    set_reload(2, "R1");
    wr(32'hF001, 1, "R3");
    wr(32'hF000, 0, "R2");
    ticks(1, "R10 setup");
    cyc(1'b1, 32'hF001, 1, 1'b1, "R10 ack wins over fire");
    set_reload(1, "R1");
    wr(32'hF000, 0, "R2");
    cyc(1'b1, 32'hF000, 0, 1'b1, "R10 R2 load wins over step");
    ticks(1, "R2 reloaded value");

    // R12: enabled but without cpu_tick nothing moves
    wr(32'hF001, 1, "R3 ack");
    set_reload(3, "R1");
    wr(32'hF000, 0, "R2");
    repeat (10) cyc(1'b0, 0, 0, 1'b0, "R12 no tick");
    ticks(2, "R12 two ticks");
    // R8: disable mid-count holds the value
    wr(32'hF001, 0, "R8 disable");
    ticks(10, "R8 hold");
    wr(32'hF001, 1, "R8 re-enable");
    ticks(1, "R8 resumes and fires");
    // R1: alias address bits outside the mask still select nibble by bits 1:0
    wr(32'hF001, 1, "R3 ack");
    set_reload(0, "R1");
    wr(32'hE00D, 4, "R1 alias nibble1");
    wr(32'hF000, 0, "R2");
    ticks(64, "R1 nibble position");

    // R11: reset mid-operation clears everything
    rst_n = 1'b0;
    @(negedge clk);
    model_reset();
    check("R11 reset mid-run", int'(irq), 0);
    rst_n = 1'b1;
    wr(32'hF001, 1, "R11 enable");
    wr(32'hF000, 0, "R11 nibbles cleared");
    ticks(40, "R11 counter wraps from zero");

    // random mix over every decoded and ignored address
    for (int i = 0; i < 6000; i++) begin
      int r, a, d;
      r = $urandom;
      case ((r >> 4) % 9)
        0: a = 32'hE000; 1: a = 32'hE001; 2: a = 32'hE002; 3: a = 32'hE003;
        4: a = 32'hF000; 5: a = 32'hF001; 6: a = 32'hF002; 7: a = 32'h9003;
        default: a = 32'hE7F0;
      endcase
      d = (r >> 8) & 15;
      if (a == 32'hE002 || a == 32'hE003) d = d & 1;
      cyc((r % 4) == 0, a, d, ((r >> 12) % 4) != 0, "R5 R6 R10 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule